// File: doc/BRIEF.md
# Rotation-Recursive Quadrature Oscillator

This block produces a cosine and a sine sample stream together, without any stored waveform table. It keeps a two-component vector (cos, sin) in signed Q1.15. On every enabled step it turns the vector by a fixed angle, given as a programmable coefficient pair (cos of the angle, sin of the angle) in signed Q1.15. Each output component is a two-product sum. Fixed-point rounding makes the vector length wander, so each step also applies a first-order length correction.

The reference length is a power of two, 2^AMP_LOG2, which is 16384 (0.5 full scale) by default. The correction gain is taken from the squared length of the vector before the step. It is equal to one when the vector lies exactly on the reference circle. A surrounding design sets the coefficient pair and pulses the step strobe at the sample rate. It then takes the two samples in the cycle where the valid flag is high.

Top module: `rot_sincos_osc`

## Requirements
- R1: While rst_n is low at a rising clock edge, after that edge cos_o = 2^AMP_LOG2 (16384 by default), sin_o = 0 and valid_o = 0.
- R2: With state (c, s) and coefficients kc = rot_cos_i and ks = rot_sin_i, all signed two's complement with 15 fraction bits, the rotated pair is rc = clamp((c·kc − s·ks + 2^14) >>> 15) and rs = clamp((s·kc + c·ks + 2^14) >>> 15). Here >>> is an arithmetic shift and clamp limits a value to [−32768, 32767]. A coefficient pair of (0, 0) therefore drives both outputs to 0.
- R3: The gain is g = 98304 − ((c² + s²) >>> 13), a signed value with 16 fraction bits, computed from the state before the step. The new state is clamp((rc·g + 2^15) >>> 16) for the cosine and the same with rs for the sine. From reset, two steps with kc = ks = 32767 give (16384, 16384) and then (0, 16384).
- R4: With a coefficient pair rounded from 32767·(cos θ, sin θ), the vector length sqrt(cos_o² + sin_o²) stays within 16384 ± 32 over at least 2000 consecutive steps.
- R5: A rising edge where step_en_i is low leaves cos_o and sin_o unchanged.
- R6: valid_o is high in the cycle after each edge that samples step_en_i high, and low after each edge that samples it low.
- R7: The coefficients are used only at an edge where step_en_i is high. Changing them between steps has no effect on the outputs until the next enabled step, and that step uses the new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en_i | input | 1 | Perform one rotation step at this edge |
| rot_cos_i | input | W | Cosine of the step angle, signed Q1.15 |
| rot_sin_i | input | W | Sine of the step angle, signed Q1.15 |
| cos_o | output | W | Cosine sample, signed Q1.15 |
| sin_o | output | W | Sine sample, signed Q1.15 |
| valid_o | output | 1 | New sample pair present |

## Verification
The hardest behaviour to reach from the ports is the long-run length regulation. Length drift only shows after hundreds of steps with a near-unit coefficient pair, and the error stays bounded only because the gain correction cancels the coefficient quantisation loss at every step. The stimulus resets the block and drives 2000 back-to-back steps at one small angle, checking the length band and the exact sample values at every step. Constrained random phases then mix idle cycles, coefficient changes between steps and occasional full-range coefficient pairs. These push the vector well off the reference circle, so the negative-gain and large-product paths are exercised.

// File: rtl/osc_pkg.sv
// Package osc_pkg
// Default widths and scaling for the rotation oscillator.
// Assumes Q1.15 samples and a power-of-two reference length.
package osc_pkg;
    localparam int OSC_W        = 16;  // sample and coefficient width
    localparam int OSC_AMP_LOG2 = 14;  // reference length = 2**OSC_AMP_LOG2
    localparam int OSC_GF       = 16;  // fraction bits of the correction gain
endpackage

// File: rtl/osc_rot_lane.sv
// Module osc_rot_lane
// One component of a complex rotation: r = a*x -/+ b*y, rounded half up
// back to W-1 fraction bits and clamped to the signed W-bit range.
// Assumes a, b are samples and x, y are coefficients, all with W-1 fraction bits.
module osc_rot_lane #(
    parameter int W        = 16,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] b_i,
    input  logic signed [W-1:0] y_i,
    output logic signed [W-1:0] r_o
);
    localparam int PW = 2 * W + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (W - 2);
    localparam logic signed [PW-1:0] MAXV = (PW'(1) << (W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) << (W - 1));

    logic signed [PW-1:0] p_ax;
    logic signed [PW-1:0] p_by;
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] rnd;

    // Both products at full precision.
    always_comb begin
        p_ax = PW'(a_i) * PW'(x_i);
        p_by = PW'(b_i) * PW'(y_i);
    end

    // The parameter picks the combining operator for this component.
    generate
        if (SUBTRACT) begin : g_sub
            always_comb acc = p_ax - p_by;
        end else begin : g_add
            always_comb acc = p_ax + p_by;
        end
    endgenerate

    // Round half up, drop the fraction bits, then clamp.
    always_comb begin
        rnd = (acc + HALF) >>> (W - 1);
        if (rnd > MAXV)
            r_o = W'(MAXV);
        else if (rnd < MINV)
            r_o = W'(MINV);
        else
            r_o = W'(rnd);
    end
endmodule

// File: rtl/osc_gain.sv
// Module osc_gain
// First-order length correction gain g = 1.5 - |v|^2 / (2 * R^2), where
// R = 2**AMP_LOG2, returned as a signed value with GF fraction bits.
// Assumes 2*AMP_LOG2 + 1 >= GF, so the scaling is a plain right shift.
module osc_gain #(
    parameter int W        = 16,
    parameter int AMP_LOG2 = 14,
    parameter int GF       = 16,
    parameter int GW       = GF + 4
) (
    input  logic signed [W-1:0]  c_i,
    input  logic signed [W-1:0]  s_i,
    output logic signed [GW-1:0] g_o
);
    localparam int MW = 2 * W + 1;
    localparam int SH = 2 * AMP_LOG2 + 1 - GF;
    localparam logic signed [MW-1:0] THREE_HALF = MW'(3) << (GF - 1);

    logic signed [MW-1:0] mag2;

    // Squared length of the current vector.
    always_comb mag2 = MW'(c_i) * MW'(c_i) + MW'(s_i) * MW'(s_i);

    // Gain of one on the reference circle, below one outside it.
    always_comb g_o = GW'(THREE_HALF - (mag2 >>> SH));
endmodule

// File: rtl/osc_scale.sv
// Module osc_scale
// Multiplies one rotated component by the correction gain, rounds half up
// and clamps the result to the signed W-bit range.
// Assumes the gain carries GF fraction bits.
module osc_scale #(
    parameter int W  = 16,
    parameter int GF = 16,
    parameter int GW = GF + 4
) (
    input  logic signed [W-1:0]  v_i,
    input  logic signed [GW-1:0] g_i,
    output logic signed [W-1:0]  v_o
);
    localparam int PW = W + GW;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (GF - 1);
    localparam logic signed [PW-1:0] MAXV = (PW'(1) << (W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) << (W - 1));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    // Scaled, rounded and clamped component.
    always_comb begin
        prod = PW'(v_i) * PW'(g_i);
        rnd  = (prod + HALF) >>> GF;
        if (rnd > MAXV)
            v_o = W'(MAXV);
        else if (rnd < MINV)
            v_o = W'(MINV);
        else
            v_o = W'(rnd);
    end
endmodule

// File: rtl/rot_sincos_osc.sv
// Module rot_sincos_osc
// Quadrature oscillator without a waveform table. Each enabled step turns
// the stored (cos, sin) vector by the programmed coefficient pair and then
// applies a first-order length correction computed from the pre-step vector.
// Assumes a synchronous active-low reset and Q1.15 coefficients.
module rot_sincos_osc #(
    parameter int W        = osc_pkg::OSC_W,
    parameter int AMP_LOG2 = osc_pkg::OSC_AMP_LOG2,
    parameter int GF       = osc_pkg::OSC_GF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en_i,
    input  logic signed [W-1:0] rot_cos_i,
    input  logic signed [W-1:0] rot_sin_i,
    output logic signed [W-1:0] cos_o,
    output logic signed [W-1:0] sin_o,
    output logic                valid_o
);
    localparam int GW = GF + 4;
    localparam logic signed [W-1:0] AMP = W'(1) << AMP_LOG2;

    logic signed [W-1:0]  c_q;
    logic signed [W-1:0]  s_q;
    logic                 vld_q;
    logic signed [W-1:0]  cur  [2];
    logic signed [W-1:0]  rotd [2];
    logic signed [W-1:0]  nxt  [2];
    logic signed [GW-1:0] gain;

    // Present the state as an indexed pair: 0 is cosine, 1 is sine.
    always_comb begin
        cur[0] = c_q;
        cur[1] = s_q;
    end

    // Correction gain from the vector held before this step.
    osc_gain #(.W(W), .AMP_LOG2(AMP_LOG2), .GF(GF), .GW(GW)) u_gain (
        .c_i (c_q),
        .s_i (s_q),
        .g_o (gain)
    );

    // Component 0 subtracts the cross term, component 1 adds it.
    generate
        for (genvar i = 0; i < 2; i++) begin : g_comp
            osc_rot_lane #(.W(W), .SUBTRACT(i == 0)) u_rot (
                .a_i (cur[i]),
                .x_i (rot_cos_i),
                .b_i (cur[1-i]),
                .y_i (rot_sin_i),
                .r_o (rotd[i])
            );
            osc_scale #(.W(W), .GF(GF), .GW(GW)) u_scale (
                .v_i (rotd[i]),
                .g_i (gain),
                .v_o (nxt[i])
            );
        end
    endgenerate

    // State update on enabled steps; valid marks the step just taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q   <= AMP;
            s_q   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= step_en_i;
            if (step_en_i) begin
                c_q <= nxt[0];
                s_q <= nxt[1];
            end
        end
    end

    always_comb begin
        cos_o   = c_q;
        sin_o   = s_q;
        valid_o = vld_q;
    end
endmodule

// File: rtl/rot_sincos_osc_checker.sv
// Module rot_sincos_osc_checker
// Port-level temporal properties of the oscillator, attached by bind.
// Assumes the same parameters as the bound instance.
module rot_sincos_osc_checker #(
    parameter int W        = 16,
    parameter int AMP_LOG2 = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step_en_i,
    input logic signed [W-1:0] rot_cos_i,
    input logic signed [W-1:0] rot_sin_i,
    input logic signed [W-1:0] cos_o,
    input logic signed [W-1:0] sin_o,
    input logic                valid_o
);
    localparam logic signed [W-1:0] AMP = W'(1) << AMP_LOG2;

    // R1: reset loads the reference vector and clears valid
    p_reset_load_r1: assert property (@(posedge clk)
        !rst_n |=> (cos_o == AMP && sin_o == '0 && !valid_o));

    // R5: an idle edge keeps both samples
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en_i |=> ($stable(cos_o) && $stable(sin_o)));

    // R6: an enabled edge raises valid for the next cycle
    p_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_en_i |=> valid_o);

    // R6: an idle edge leaves valid low
    p_valid_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en_i |=> !valid_o);

    // R2: a zero coefficient pair collapses the vector
    p_zero_coef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && rot_cos_i == '0 && rot_sin_i == '0) |=>
            (cos_o == '0 && sin_o == '0));

    // R7: samples change only after an enabled edge
    p_change_needs_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_o != $past(cos_o) || sin_o != $past(sin_o)) |-> valid_o);
endmodule

bind rot_sincos_osc rot_sincos_osc_checker #(.W(W), .AMP_LOG2(AMP_LOG2)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en_i (step_en_i),
    .rot_cos_i (rot_cos_i),
    .rot_sin_i (rot_sin_i),
    .cos_o     (cos_o),
    .sin_o     (sin_o),
    .valid_o   (valid_o)
);

// File: tb/rot_sincos_osc_tb_top.sv
// Bench for rot_sincos_osc: directed corner cases plus seeded random steps,
// compared against an arithmetic model written from the requirements.
module rot_sincos_osc_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               step_en_i = 1'b0;
    logic signed [15:0] rot_cos_i = '0;
    logic signed [15:0] rot_sin_i = '0;
    logic signed [15:0] cos_o;
    logic signed [15:0] sin_o;
    logic               valid_o;

    int     n_checks = 0;
    int     n_errors = 0;
    bit     finished = 1'b0;
    longint mc = 16384;
    longint ms = 0;

    always #5 clk = ~clk;

    rot_sincos_osc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en_i (step_en_i),
        .rot_cos_i (rot_cos_i),
        .rot_sin_i (rot_sin_i),
        .cos_o     (cos_o),
        .sin_o     (sin_o),
        .valid_o   (valid_o)
    );

    function automatic longint clamp16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint m_rot(input longint a, input longint x,
                                     input longint b, input longint y, input bit sub);
        longint acc;
        acc = sub ? (a * x - b * y) : (a * x + b * y);
        return clamp16((acc + 16384) >>> 15);
    endfunction

    function automatic longint m_gain(input longint c, input longint s);
        return 98304 - ((c * c + s * s) >>> 13);
    endfunction

    function automatic longint m_scale(input longint v, input longint g);
        return clamp16((v * g + 32768) >>> 16);
    endfunction

    function automatic int q15(input real v);
        int r;
        r = int'(v * 32767.0);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic chk(input longint act, input longint exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        step_en_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mc = 16384;
        ms = 0;
        chk(longint'(cos_o), 16384, "R1", "cos after reset");
        chk(longint'(sin_o), 0, "R1", "sin after reset");
        chk(longint'(valid_o), 0, "R1", "valid after reset");
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next falling edge.
    task automatic tick(input bit en, input int kc, input int ks, input string req);
        longint g, nc, ns;
        step_en_i = en;
        rot_cos_i = 16'(kc);
        rot_sin_i = 16'(ks);
        if (en) begin
            g  = m_gain(mc, ms);
            nc = m_scale(m_rot(mc, kc, ms, ks, 1'b1), g);
            ns = m_scale(m_rot(ms, kc, mc, ks, 1'b0), g);
            mc = nc;
            ms = ns;
        end
        @(negedge clk);
        chk(longint'(cos_o), mc, req, "cos");
        chk(longint'(sin_o), ms, req, "sin");
        chk(longint'(valid_o), longint'(en), "R6", "valid");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int kc_u;
        int ks_u;
        real mag;
        void'($urandom(32'd7741));
        @(negedge clk);
        do_reset();

        // R3: directed two-step sequence with over-unit coefficients
        tick(1'b1, 32767, 32767, "R3");
        chk(longint'(cos_o), 16384, "R3", "first step cos");
        chk(longint'(sin_o), 16384, "R3", "first step sin");
        tick(1'b1, 32767, 32767, "R3");
        chk(longint'(cos_o), 0, "R3", "second step cos");
        chk(longint'(sin_o), 16384, "R3", "second step sin");

        // R5 and R7: idle edges with changing coefficients leave samples alone
        for (int i = 0; i < 6; i++)
            tick(1'b0, int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768, "R5/R7");
        // R7: the next enabled step uses the pair presented at that edge
        tick(1'b1, q15(0.8), q15(-0.6), "R7");

        // R2: a zero coefficient pair drives both samples to zero
        tick(1'b1, 0, 0, "R2");
        chk(longint'(cos_o), 0, "R2", "zero coef cos");
        chk(longint'(sin_o), 0, "R2", "zero coef sin");

        // R4: long run at a small angle, length held in a band
        do_reset();
        kc_u = q15($cos(6.283185307179586 / 100.0));
        ks_u = q15($sin(6.283185307179586 / 100.0));
        for (int i = 0; i < 2000; i++) begin
            tick(1'b1, kc_u, ks_u, "R2/R3");
            mag = $sqrt(real'(longint'(cos_o) * longint'(cos_o) + longint'(sin_o) * longint'(sin_o)));
            n_checks++;
            if (mag < 16352.0 || mag > 16416.0) begin
                n_errors++;
                $display("FAIL R4 length actual=%0f expected=16384+-32 step=%0d", mag, i);
            end
        end

        // R2, R3, R5, R6: random mix of steps, idles, angles and full-range pairs
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            bit en;
            int kc;
            int ks;
            real ang;
            en = (($urandom % 10) < 7);
            if (($urandom % 8) == 0) begin
                kc = int'($urandom % 65536) - 32768;
                ks = int'($urandom % 65536) - 32768;
            end else begin
                ang = real'($urandom % 100000) * 6.283185307179586 / 100000.0;
                kc = q15($cos(ang));
                ks = q15($sin(ang));
            end
            tick(en, kc, ks, en ? "R2/R3" : "R5");
            if (($urandom % 500) == 0) do_reset();
        end

        // R1: reset in the middle of operation restores the reference vector
        tick(1'b1, q15(0.5), q15(0.5), "R2/R3");
        do_reset();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule